// File: doc/BRIEF.md
# AXI4-Lite Split Status/Control Register Bank

This block is an AXI4-Lite slave that presents a map of 32 words, each 32 bits wide, to a bus master. Word `i` sits at byte offset `4*i`. The lowest eight words are status words: they carry values that the surrounding fabric drives on an input bus, and a write to them has no effect. The remaining twenty-four words are control registers. The master writes them, they drive an output bus into the fabric, and the read path never returns their contents. The block is used wherever software must set parameters of fabric logic and read its status over a memory-mapped link.

The two directions run as separate state machines. The write machine has four states. `WR_IDLE` accepts both address and data. `WR_GOT_ADDR` holds a latched address and waits for data. `WR_GOT_DATA` holds latched data and strobes and waits for an address. `WR_RESP` drives the response until it is taken. The write transitions are:
- idle to resp when address and data arrive in the same cycle;
- idle to got_addr when the address arrives alone;
- idle to got_data when the data arrives alone;
- got_addr to resp when the data arrives;
- got_data to resp when the address arrives;
- resp to idle when the response is taken.

The register is written on the edge that enters `WR_RESP`.

The read machine has two states. `RD_IDLE` accepts an address. `RD_HOLD` drives the captured word until it is taken. A read-address handshake moves idle to hold, and the data handshake moves hold back to idle.

Top module: `regbank_axil`

## Requirements
- R1: While `rst_n` is low and after its release, `bvalid` and `rvalid` are 0 and every control register (all of `ctl_out`) is 0.
- R2: A write to word index 8..31 (index = address bits [6:2]; address bits [1:0] are ignored) updates control register `idx-8`, which drives `ctl_out[(idx-8)*32 +: 32]`.
- R3: Write strobe bit k enables byte lane k (data bits [8k+7:8k]) of the addressed control register; lanes whose strobe is 0 keep their value, and an all-zero strobe changes nothing.
- R4: A write to word index 0..7 completes with response OKAY (`bresp` = 2'b00) and changes no control register.
- R5: A read of word index 0..7 returns status word `stat_in[idx*32 +: 32]` as sampled on the read-address handshake edge, with `rresp` = 2'b00.
- R6: A read of word index 8..31 returns 0 with `rresp` = 2'b00, whatever the control registers hold.
- R7: Write address and write data may arrive in the same cycle or in either order. No register changes and `bvalid` stays 0 until both have been accepted. After that, exactly one response follows.
- R8: Once `bvalid` rises it stays high, with `bresp` = 2'b00, until a cycle in which `bready` is high. While it is high, `awready` and `wready` are 0.
- R9: Once `rvalid` rises, it and `rdata` hold until a cycle in which `rready` is high. While it is high, `arready` is 0.
- R10: The read and write channels are independent: a read and a write may be in flight at the same time and both complete correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs sampled on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| awaddr | input | ADDR_W (7) | Write address (byte) |
| awvalid | input | 1 | Write address valid |
| awready | output | 1 | Write address ready |
| wdata | input | DATA_W (32) | Write data |
| wstrb | input | DATA_W/8 (4) | Write byte strobes |
| wvalid | input | 1 | Write data valid |
| wready | output | 1 | Write data ready |
| bresp | output | 2 | Write response, always OKAY |
| bvalid | output | 1 | Write response valid |
| bready | input | 1 | Write response ready |
| araddr | input | ADDR_W (7) | Read address (byte) |
| arvalid | input | 1 | Read address valid |
| arready | output | 1 | Read address ready |
| rdata | output | DATA_W (32) | Read data |
| rresp | output | 2 | Read response, always OKAY |
| rvalid | output | 1 | Read data valid |
| rready | input | 1 | Read data ready |
| stat_in | input | N_STAT*DATA_W (256) | Status words from the fabric, word k in bits [k*32 +: 32] |
| ctl_out | output | N_CTL*DATA_W (768) | Control registers to the fabric, register j in bits [j*32 +: 32] |

## Verification
The bench builds the block with its default parameters: N_STAT=8, N_CTL=24, DATA_W=32 and ADDR_W=7. With these values every address the bus can form is a real register, so a full sweep covers both ends of each region and the 7/8 boundary between them. Writes are issued with all three address/data orderings and with delayed response acceptance, and reads use delayed data acceptance. Status inputs change right after a read-address handshake, which pins down the sampling edge.

// File: rtl/regbank_pkg.sv
package regbank_pkg;

    typedef enum logic [1:0] {
        WR_IDLE,
        WR_GOT_ADDR,
        WR_GOT_DATA,
        WR_RESP
    } wr_state_t;

    typedef enum logic {
        RD_IDLE,
        RD_HOLD
    } rd_state_t;

    localparam logic [1:0] RESP_OKAY = 2'b00;

endpackage

// File: rtl/regbank_wr_ctrl.sv
module regbank_wr_ctrl
    import regbank_pkg::*;
#(
    parameter int ADDR_W = 7,
    parameter int DATA_W = 32,
    parameter int IDX_W  = 5,
    parameter int STRB_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] awaddr,
    input  logic              awvalid,
    output logic              awready,
    input  logic [DATA_W-1:0] wdata,
    input  logic [STRB_W-1:0] wstrb,
    input  logic              wvalid,
    output logic              wready,
    output logic [1:0]        bresp,
    output logic              bvalid,
    input  logic              bready,
    output logic              commit,
    output logic [IDX_W-1:0]  commit_idx,
    output logic [DATA_W-1:0] commit_data,
    output logic [STRB_W-1:0] commit_strb
);

    wr_state_t         state_q;
    wr_state_t         state_d;
    logic              aw_hs;
    logic              w_hs;
    logic [IDX_W-1:0]  addr_q;
    logic [DATA_W-1:0] data_q;
    logic [STRB_W-1:0] strb_q;
    logic              unused_lo;

    assign unused_lo = ^awaddr[1:0];
    assign aw_hs     = awvalid && awready;
    assign w_hs      = wvalid && wready;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= WR_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WR_IDLE: begin
                if (aw_hs && w_hs)  state_d = WR_RESP;
                else if (aw_hs)     state_d = WR_GOT_ADDR;
                else if (w_hs)      state_d = WR_GOT_DATA;
            end
            WR_GOT_ADDR: if (w_hs)   state_d = WR_RESP;
            WR_GOT_DATA: if (aw_hs)  state_d = WR_RESP;
            WR_RESP:     if (bready) state_d = WR_IDLE;
            default:                 state_d = WR_IDLE;
        endcase
    end

    always_comb begin
        awready = 1'b0;
        wready  = 1'b0;
        bvalid  = 1'b0;
        unique case (state_q)
            WR_IDLE: begin
                awready = 1'b1;
                wready  = 1'b1;
            end
            WR_GOT_ADDR: wready  = 1'b1;
            WR_GOT_DATA: awready = 1'b1;
            WR_RESP:     bvalid  = 1'b1;
            default: begin
                awready = 1'b0;
            end
        endcase
    end

    assign bresp = RESP_OKAY;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            data_q <= '0;
            strb_q <= '0;
        end else begin
            if (aw_hs) addr_q <= awaddr[ADDR_W-1:2];
            if (w_hs) begin
                data_q <= wdata;
                strb_q <= wstrb;
            end
        end
    end

    assign commit      = (state_d == WR_RESP) && (state_q != WR_RESP);
    assign commit_idx  = aw_hs ? awaddr[ADDR_W-1:2] : addr_q;
    assign commit_data = w_hs ? wdata : data_q;
    assign commit_strb = w_hs ? wstrb : strb_q;

    // R8
    bvalid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bvalid && !bready |=> bvalid);
    // R8
    no_accept_in_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bvalid |-> !awready && !wready);
    // R7
    commit_then_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> bvalid);

endmodule

// File: rtl/regbank_rd_ctrl.sv
module regbank_rd_ctrl
    import regbank_pkg::*;
#(
    parameter int ADDR_W = 7,
    parameter int DATA_W = 32,
    parameter int IDX_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] araddr,
    input  logic              arvalid,
    output logic              arready,
    output logic [DATA_W-1:0] rdata,
    output logic [1:0]        rresp,
    output logic              rvalid,
    input  logic              rready,
    output logic [IDX_W-1:0]  rd_idx,
    input  logic [DATA_W-1:0] rd_word
);

    rd_state_t         state_q;
    rd_state_t         state_d;
    logic              ar_hs;
    logic [DATA_W-1:0] rdata_q;
    logic              unused_lo;

    assign unused_lo = ^araddr[1:0];
    assign ar_hs     = arvalid && arready;
    assign rd_idx    = araddr[ADDR_W-1:2];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RD_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RD_IDLE: if (ar_hs)  state_d = RD_HOLD;
            RD_HOLD: if (rready) state_d = RD_IDLE;
            default:             state_d = RD_IDLE;
        endcase
    end

    always_comb begin
        arready = 1'b0;
        rvalid  = 1'b0;
        unique case (state_q)
            RD_IDLE: arready = 1'b1;
            RD_HOLD: rvalid  = 1'b1;
            default: arready = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (ar_hs) begin
            rdata_q <= rd_word;
        end
    end

    assign rdata = rdata_q;
    assign rresp = RESP_OKAY;

    // R9
    rvalid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid && !rready |=> rvalid && $stable(rdata));
    // R9
    no_ar_in_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid |-> !arready);

endmodule

// File: rtl/regbank_ctl_store.sv
module regbank_ctl_store #(
    parameter int N_STAT = 8,
    parameter int N_CTL  = 24,
    parameter int DATA_W = 32,
    parameter int IDX_W  = 5,
    parameter int STRB_W = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    commit,
    input  logic [IDX_W-1:0]        commit_idx,
    input  logic [DATA_W-1:0]       commit_data,
    input  logic [STRB_W-1:0]       commit_strb,
    output logic [N_CTL*DATA_W-1:0] ctl_flat
);

    for (genvar g = 0; g < N_CTL; g++) begin : g_reg
        logic hit;
        assign hit = commit && (commit_idx == IDX_W'(N_STAT + g));
        for (genvar b = 0; b < STRB_W; b++) begin : g_lane
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    ctl_flat[g*DATA_W + b*8 +: 8] <= '0;
                end else if (hit && commit_strb[b]) begin
                    ctl_flat[g*DATA_W + b*8 +: 8] <= commit_data[b*8 +: 8];
                end
            end
        end
    end

    // R4
    ro_write_inert_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit && (commit_idx < IDX_W'(N_STAT)) |=> $stable(ctl_flat));
    // R3
    zero_strobe_inert_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit && (commit_strb == '0) |=> $stable(ctl_flat));

endmodule

// File: rtl/regbank_rd_mux.sv
module regbank_rd_mux #(
    parameter int N_STAT = 8,
    parameter int DATA_W = 32,
    parameter int IDX_W  = 5
) (
    input  logic [IDX_W-1:0]         rd_idx,
    input  logic [N_STAT*DATA_W-1:0] stat_flat,
    output logic [DATA_W-1:0]        rd_word
);

    always_comb begin
        rd_word = '0;
        for (int k = 0; k < N_STAT; k++) begin
            if (rd_idx == IDX_W'(k)) begin
                rd_word = stat_flat[k*DATA_W +: DATA_W];
            end
        end
    end

endmodule

// File: rtl/regbank_axil.sv
module regbank_axil #(
    parameter int ADDR_W = 7,
    parameter int DATA_W = 32,
    parameter int N_STAT = 8,
    parameter int N_CTL  = 24
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [ADDR_W-1:0]        awaddr,
    input  logic                     awvalid,
    output logic                     awready,
    input  logic [DATA_W-1:0]        wdata,
    input  logic [DATA_W/8-1:0]      wstrb,
    input  logic                     wvalid,
    output logic                     wready,
    output logic [1:0]               bresp,
    output logic                     bvalid,
    input  logic                     bready,
    input  logic [ADDR_W-1:0]        araddr,
    input  logic                     arvalid,
    output logic                     arready,
    output logic [DATA_W-1:0]        rdata,
    output logic [1:0]               rresp,
    output logic                     rvalid,
    input  logic                     rready,
    input  logic [N_STAT*DATA_W-1:0] stat_in,
    output logic [N_CTL*DATA_W-1:0]  ctl_out
);

    localparam int IDX_W  = ADDR_W - 2;
    localparam int STRB_W = DATA_W / 8;

    logic              commit;
    logic [IDX_W-1:0]  commit_idx;
    logic [DATA_W-1:0] commit_data;
    logic [STRB_W-1:0] commit_strb;
    logic [IDX_W-1:0]  rd_idx;
    logic [DATA_W-1:0] rd_word;

    regbank_wr_ctrl #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W), .STRB_W(STRB_W)
    ) u_wr (
        .clk(clk), .rst_n(rst_n),
        .awaddr(awaddr), .awvalid(awvalid), .awready(awready),
        .wdata(wdata), .wstrb(wstrb), .wvalid(wvalid), .wready(wready),
        .bresp(bresp), .bvalid(bvalid), .bready(bready),
        .commit(commit), .commit_idx(commit_idx),
        .commit_data(commit_data), .commit_strb(commit_strb)
    );

    regbank_ctl_store #(
        .N_STAT(N_STAT), .N_CTL(N_CTL), .DATA_W(DATA_W),
        .IDX_W(IDX_W), .STRB_W(STRB_W)
    ) u_store (
        .clk(clk), .rst_n(rst_n),
        .commit(commit), .commit_idx(commit_idx),
        .commit_data(commit_data), .commit_strb(commit_strb),
        .ctl_flat(ctl_out)
    );

    regbank_rd_mux #(
        .N_STAT(N_STAT), .DATA_W(DATA_W), .IDX_W(IDX_W)
    ) u_mux (
        .rd_idx(rd_idx), .stat_flat(stat_in), .rd_word(rd_word)
    );

    regbank_rd_ctrl #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)
    ) u_rd (
        .clk(clk), .rst_n(rst_n),
        .araddr(araddr), .arvalid(arvalid), .arready(arready),
        .rdata(rdata), .rresp(rresp), .rvalid(rvalid), .rready(rready),
        .rd_idx(rd_idx), .rd_word(rd_word)
    );

    // R10
    chan_indep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bvalid && rvalid && !bready && !rready |=> bvalid && rvalid);

endmodule

// File: tb/regbank_axil_bench.sv
module regbank_axil_bench;

    localparam int ADDR_W = 7;
    localparam int DATA_W = 32;
    localparam int N_STAT = 8;
    localparam int N_CTL  = 24;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [ADDR_W-1:0] awaddr = '0, araddr = '0;
    logic awvalid = 1'b0, wvalid = 1'b0, bready = 1'b0, arvalid = 1'b0, rready = 1'b0;
    logic [DATA_W-1:0] wdata = '0;
    logic [3:0] wstrb = '0;
    logic awready, wready, bvalid, arready, rvalid;
    logic [1:0] bresp, rresp;
    logic [DATA_W-1:0] rdata;
    logic [N_STAT*DATA_W-1:0] stat_in = '0;
    logic [N_CTL*DATA_W-1:0] ctl_out;

    int checks = 0;
    int errors = 0;
    logic [31:0] model [N_CTL];
    logic [31:0] rd_exp_q [$];
    string       rd_tag_q [$];
    string       b_tag_q [$];

    always #2 clk = ~clk;

    regbank_axil #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .N_STAT(N_STAT), .N_CTL(N_CTL)) u_regbank_axil (
        .clk(clk), .rst_n(rst_n),
        .awaddr(awaddr), .awvalid(awvalid), .awready(awready),
        .wdata(wdata), .wstrb(wstrb), .wvalid(wvalid), .wready(wready),
        .bresp(bresp), .bvalid(bvalid), .bready(bready),
        .araddr(araddr), .arvalid(arvalid), .arready(arready),
        .rdata(rdata), .rresp(rresp), .rvalid(rvalid), .rready(rready),
        .stat_in(stat_in), .ctl_out(ctl_out)
    );

    task automatic check(input logic ok, input string tag, input logic [N_CTL*DATA_W-1:0] act,
                         input logic [N_CTL*DATA_W-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [N_CTL*DATA_W-1:0] model_flat();
        logic [N_CTL*DATA_W-1:0] f;
        for (int j = 0; j < N_CTL; j++) f[j*DATA_W +: DATA_W] = model[j];
        return f;
    endfunction

    // monitor: pops expected items as the design presents results
    always @(negedge clk) begin
        if (rst_n && rvalid && rready) begin
            if (rd_exp_q.size() == 0) begin
                check(1'b0, "R9 unexpected read data", {736'b0, rdata}, '0);
            end else begin
                logic [31:0] e;
                string t;
                e = rd_exp_q.pop_front();
                t = rd_tag_q.pop_front();
                check(rdata == e && rresp == 2'b00, t, {734'b0, rresp, rdata}, {736'b0, e});
            end
        end
        if (rst_n && bvalid && bready) begin
            if (b_tag_q.size() == 0) begin
                check(1'b0, "R7 unexpected write response", '0, '0);
            end else begin
                string t;
                t = b_tag_q.pop_front();
                check(bresp == 2'b00, t, {766'b0, bresp}, '0);
            end
        end
    end

    task automatic do_write(input logic [ADDR_W-1:0] addr, input logic [31:0] data,
                            input logic [3:0] strb, input int order, input int hold, input string tag);
        bit aw_done = 0, w_done = 0, gap_done = 0;
        int idx;
        b_tag_q.push_back({tag, " bresp"});
        @(posedge clk); #1;
        awaddr = addr; wdata = data; wstrb = strb;
        awvalid = (order != 2);
        wvalid  = (order != 1);
        while (!(aw_done && w_done)) begin
            bit a_hs, w_hs;
            @(negedge clk);
            a_hs = awvalid && awready;
            w_hs = wvalid && wready;
            @(posedge clk); #1;
            if (a_hs) begin awvalid = 1'b0; aw_done = 1; end
            if (w_hs) begin wvalid = 1'b0; w_done = 1; end
            if ((aw_done ^ w_done) && !gap_done) begin
                repeat (2) @(posedge clk);
                @(negedge clk);
                check(!bvalid && ctl_out == model_flat(), "R7 no write before both halves",
                      ctl_out, model_flat());
                gap_done = 1;
                @(posedge clk); #1;
            end
            if (!aw_done && !awvalid) awvalid = 1'b1;
            if (!w_done && !wvalid) wvalid = 1'b1;
        end
        for (int h = 0; h < hold; h++) begin
            @(negedge clk);
            check(bvalid == 1'b1 && !awready && !wready, "R8 bvalid held, channels closed",
                  {765'b0, bvalid, awready, wready}, {765'b0, 3'b100});
        end
        @(posedge clk); #1;
        bready = 1'b1;
        @(posedge clk); #1;
        bready = 1'b0;
        idx = int'(addr[ADDR_W-1:2]);
        if (idx >= N_STAT && idx < N_STAT + N_CTL) begin
            for (int b = 0; b < 4; b++)
                if (strb[b]) model[idx-N_STAT][b*8 +: 8] = data[b*8 +: 8];
        end
        @(negedge clk);
        check(ctl_out == model_flat(), tag, ctl_out, model_flat());
    endtask

    task automatic do_read(input logic [ADDR_W-1:0] addr, input int hold, input bit perturb,
                           input string tag);
        int idx;
        logic [31:0] first;
        idx = int'(addr[ADDR_W-1:2]);
        @(posedge clk); #1;
        araddr = addr;
        arvalid = 1'b1;
        @(negedge clk);
        while (!arready) @(negedge clk);
        rd_exp_q.push_back(idx < N_STAT ? stat_in[idx*DATA_W +: DATA_W] : 32'h0);
        rd_tag_q.push_back(tag);
        @(posedge clk); #1;
        arvalid = 1'b0;
        if (perturb) stat_in = ~stat_in;
        @(negedge clk);
        first = rdata;
        for (int h = 0; h < hold; h++) begin
            @(negedge clk);
            check(rvalid && rdata == first && !arready, "R9 rvalid/rdata held",
                  {735'b0, rvalid, rdata}, {735'b0, 1'b1, first});
        end
        @(posedge clk); #1;
        rready = 1'b1;
        @(posedge clk); #1;
        rready = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        check(1'b0, "watchdog expired", '0, '0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int j = 0; j < N_CTL; j++) model[j] = '0;
        for (int k = 0; k < N_STAT; k++) stat_in[k*DATA_W +: DATA_W] = 32'hA500_0000 | (k * 32'h111);
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 during reset
        check(!bvalid && !rvalid && ctl_out == '0, "R1 reset state", ctl_out, '0);
        @(posedge clk); #1;
        rst_n = 1'b1;
        @(negedge clk);
        check(!bvalid && !rvalid && ctl_out == '0, "R1 after release", ctl_out, '0);

        // R2 / R7 sweep of all control words, all three orderings
        for (int i = N_STAT; i < N_STAT + N_CTL; i++)
            do_write(ADDR_W'(4*i), {i[7:0], 8'h5A ^ i[7:0], 8'hC3, ~i[7:0]}, 4'hF, i % 3, i % 2,
                     "R2 R7 control write sweep");

        // R5 / R6 sweep of all words
        for (int i = 0; i < N_STAT + N_CTL; i++)
            do_read(ADDR_W'(4*i), i % 3, 1'b0, i < N_STAT ? "R5 status read" : "R6 control read is zero");

        // R5 sampling edge: status flips just after the handshake
        do_read(ADDR_W'(4*3), 2, 1'b1, "R5 status sampled at handshake");

        // R3 byte strobes
        do_write(ADDR_W'(4*10), 32'hDEAD_BEEF, 4'b0101, 0, 0, "R3 strobe 0101");
        do_write(ADDR_W'(4*10), 32'h1234_5678, 4'b0000, 1, 0, "R3 zero strobe");
        do_write(ADDR_W'(4*31), 32'hFFFF_FFFF, 4'b1000, 2, 1, "R3 top lane only");

        // R4 writes to status words are inert
        do_write(ADDR_W'(4*2), 32'hFFFF_FFFF, 4'hF, 0, 2, "R4 status write inert");
        do_write(ADDR_W'(4*7), 32'h0BAD_F00D, 4'hF, 1, 0, "R4 status boundary write inert");
        do_read(ADDR_W'(4*2), 0, 1'b0, "R4 status word unchanged");

        // R2 low address bits ignored
        do_write(ADDR_W'(4*12 + 3), 32'hCAFE_0012, 4'hF, 0, 0, "R2 low address bits ignored");

        // R10 concurrent read and write
        fork
            do_write(ADDR_W'(4*20), 32'h2020_2020, 4'hF, 2, 2, "R10 concurrent write");
            do_read(ADDR_W'(4*5), 1, 1'b0, "R10 concurrent read");
        join

        // R1 reset after traffic clears control registers
        @(posedge clk); #1;
        rst_n = 1'b0;
        @(posedge clk); #1;
        @(negedge clk);
        check(ctl_out == '0 && !bvalid && !rvalid, "R1 reset clears controls", ctl_out, '0);
        @(posedge clk); #1;
        rst_n = 1'b1;
        repeat (2) @(posedge clk);

        check(rd_exp_q.size() == 0 && b_tag_q.size() == 0, "R7 R9 every item answered",
              {736'b0, 32'(rd_exp_q.size() + b_tag_q.size())}, '0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule